// File: doc/BRIEF.md
# Multi-Lane Command Phase Serializer

This block sends the opcode and the address of a serial flash command. It does not handle dummy cycles, data, the receive path or chip select. A 16-bit configuration word sets the following for each of the two phases:
- the lane count: 1, 2, 4 or 8 lines, or no lines, which skips the phase;
- the width: 8, 16, 24 or 32 bits;
- the rate: single or double transfer.

A start pulse latches the opcode and the address values. The block then drives the opcode phase and the address phase back to back, most significant bit first. It produces the serial clock, an 8-bit output bus, per-line output enables and a one-cycle pulse when each phase ends.

Every serial clock half-period lasts one system clock cycle, called a tick. In each phase the serial clock is low on even ticks and high on odd ticks. The configuration register can be read back, and it is locked while a command runs. A reserved lane code skips its phase and raises a one-cycle error flag.

Top module: `cmd_phase_ser`

## Requirements
- R1: After synchronous reset, busy, sclk, phase_done and cfg_err are 0, dq_out and dq_oe are 0, and cfg_rdata is 0.
- R2: The configuration word has the following fields:
  - opcode lane code in [2:0], opcode double-rate bit in [3], opcode size in [5:4];
  - address lane code in [10:8], address double-rate bit in [11], address size in [13:12].
  - Bits [7:6] and [15:14] read back as 0 on cfg_rdata.
- R3: A write while busy is 1, or in the same cycle as an accepted start, leaves cfg_rdata unchanged.
- R4: Lane code 1, 2, 3 or 4 selects 1, 2, 4 or 8 lanes. During a phase, dq_oe enables exactly the lowest L lines. The phase sends the least significant size bits of its value MSB-first. Within each beat, the most significant bit goes on line L-1. Lines without an enable drive 0.
- R5: Size code s gives 8*(s+1) bits. At single rate a beat lasts 2 ticks, a phase lasts 2*bits/L ticks, and data changes only when a new even tick begins.
- R6: At double rate, data changes every tick. The phase lasts bits/L ticks, rounded up to an even number. A padding tick drives 0 on the enabled lines.
- R7: The opcode phase comes first. The address phase follows in the very next tick.
- R8: Lane code 0 skips that phase.
- R9: Lane codes 5 to 7 skip their phase. cfg_err is 1 for exactly the first cycle after the start.
- R10: busy rises in the cycle after an accepted start and falls in the cycle after the last tick. With both phases skipped, busy is 1 for exactly one cycle. A start while busy is ignored.
- R11: phase_done is 1 for one cycle, in the cycle after each phase's last tick.
- R12: While busy is 0, sclk, dq_out and dq_oe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rdata | output | 16 | Configuration readback |
| instr_val | input | 32 | Opcode value, sampled at start |
| addr_val | input | 32 | Address value, sampled at start |
| start | input | 1 | Start pulse |
| busy | output | 1 | Command in progress |
| sclk | output | 1 | Serial clock |
| dq_out | output | 8 | Serial data lines |
| dq_oe | output | 8 | Per-line output enables |
| phase_done | output | 1 | One-cycle end-of-phase pulse |
| cfg_err | output | 1 | One-cycle reserved-code flag |

## Verification
The first tick of the first enabled phase, busy and cfg_err all appear one cycle after the edge that samples start. Each following tick appears one cycle later. phase_done, and the return to idle, come one cycle after a phase's last tick. A configuration write becomes visible on cfg_rdata one cycle after its strobe. The bench drives inputs at the falling edge and builds the expected tick list from the configuration word alone. It then compares busy, sclk, dq_out, dq_oe, phase_done and cfg_err at every following falling edge, so each tick is checked in the cycle it is due.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_MASK = 16'h3F3F;

  typedef enum logic [1:0] {S_IDLE, S_INS, S_ADR, S_EMPTY} seq_state_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       dtr;
    logic [1:0] size;
  } phase_cfg_t;

  function automatic logic mode_ok(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  function automatic logic mode_bad(input logic [2:0] m);
    return m > 3'd4;
  endfunction

  function automatic logic [1:0] lanes_log(input logic [2:0] m);
    return 2'(m - 3'd1);
  endfunction
endpackage

// File: rtl/cps_cfg_reg.sv
module cps_cfg_reg
  import cps_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             lock,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output phase_cfg_t       ins_cfg,
  output phase_cfg_t       adr_cfg
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (we && !lock) cfg_q <= wdata & CFG_MASK;
  end

  assign rdata   = cfg_q;
  assign ins_cfg = '{mode: cfg_q[2:0],  dtr: cfg_q[3],  size: cfg_q[5:4]};
  assign adr_cfg = '{mode: cfg_q[10:8], dtr: cfg_q[11], size: cfg_q[13:12]};
endmodule

// File: rtl/cps_lane_shifter.sv
module cps_lane_shifter #(
  parameter int VAL_W = 32,
  parameter int LANES = 8,
  localparam int BW   = $clog2(VAL_W) + 1,
  localparam int LL_W = $clog2($clog2(LANES) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             adv,
  input  logic             clr,
  input  logic [VAL_W-1:0] ld_val,
  input  logic [BW-1:0]    ld_bits,
  input  logic [LL_W-1:0]  ld_llog,
  output logic [LANES-1:0] dq,
  output logic [LANES-1:0] oe
);
  logic [VAL_W-1:0] sh_q, sh_nxt;
  logic [LL_W-1:0]  llog_q, cur_l;
  logic [LANES-1:0] beat_v, mask_v;
  int               lanes_n;

  always_comb begin
    cur_l   = ld ? ld_llog : llog_q;
    lanes_n = 1 << cur_l;
    if (ld)       sh_nxt = ld_val << (VAL_W - int'(ld_bits));
    else if (adv) sh_nxt = sh_q << lanes_n;
    else          sh_nxt = sh_q;
    for (int i = 0; i < LANES; i++) begin
      mask_v[i] = (i < lanes_n);
      beat_v[i] = 1'b0;
      if (i < lanes_n) beat_v[i] = sh_nxt[VAL_W - lanes_n + i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      llog_q <= '0;
      dq     <= '0;
      oe     <= '0;
    end else begin
      sh_q <= sh_nxt;
      if (ld) llog_q <= ld_llog;
      if (clr) begin
        dq <= '0;
        oe <= '0;
      end else begin
        if (ld || adv) dq <= beat_v;
        if (ld)        oe <= mask_v;
      end
    end
  end
endmodule

// File: rtl/cps_seq.sv
module cps_seq
  import cps_pkg::*;
#(
  parameter int VAL_W = 32,
  localparam int BW   = $clog2(VAL_W) + 1,
  localparam int TW   = BW + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  phase_cfg_t ins_cfg,
  input  phase_cfg_t adr_cfg,
  output logic       busy,
  output logic       sclk,
  output logic       phase_done,
  output logic       cfg_err,
  output logic       start_acc,
  output logic       ld,
  output logic       adv,
  output logic       clr,
  output logic       ld_adr,
  output phase_cfg_t ld_cfg
);
  seq_state_e    st;
  logic [TW-1:0] tick, last;
  logic          dtr_q, in_ph, end_ph, ins_on, adr_on;

  function automatic logic [TW-1:0] ticks_of(input phase_cfg_t c);
    logic [BW-1:0] nbits, beats;
    nbits = BW'({({1'b0, c.size} + 3'd1), 3'b000});
    beats = nbits >> lanes_log(c.mode);
    return c.dtr ? (TW'(beats) + TW'(beats[0])) : {beats, 1'b0};
  endfunction

  always_comb begin
    ins_on    = mode_ok(ins_cfg.mode);
    adr_on    = mode_ok(adr_cfg.mode);
    start_acc = start && (st == S_IDLE);
    in_ph     = (st == S_INS) || (st == S_ADR);
    end_ph    = in_ph && (tick == last);
    ld_adr    = start_acc ? (!ins_on && adr_on) : (end_ph && (st == S_INS) && adr_on);
    ld        = (start_acc && ins_on) || ld_adr;
    ld_cfg    = ld_adr ? adr_cfg : ins_cfg;
    clr       = end_ph && !ld_adr;
    adv       = in_ph && !end_ph && (dtr_q || tick[0]);
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      tick       <= '0;
      last       <= '0;
      dtr_q      <= 1'b0;
      sclk       <= 1'b0;
      phase_done <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      phase_done <= end_ph;
      cfg_err    <= start_acc && (mode_bad(ins_cfg.mode) || mode_bad(adr_cfg.mode));
      if (ld) begin
        st    <= ld_adr ? S_ADR : S_INS;
        tick  <= '0;
        last  <= ticks_of(ld_cfg) - TW'(1);
        dtr_q <= ld_cfg.dtr;
        sclk  <= 1'b0;
      end else if (start_acc) begin
        st <= S_EMPTY;
      end else if (end_ph) begin
        st   <= S_IDLE;
        sclk <= 1'b0;
      end else if (in_ph) begin
        tick <= tick + TW'(1);
        sclk <= ~tick[0];
      end else begin
        st <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/cmd_phase_ser.sv
module cmd_phase_ser
  import cps_pkg::*;
#(
  parameter int VAL_W = 32,
  parameter int LANES = 8,
  localparam int BW   = $clog2(VAL_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cfg_we,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [VAL_W-1:0] instr_val,
  input  logic [VAL_W-1:0] addr_val,
  input  logic             start,
  output logic             busy,
  output logic             sclk,
  output logic [LANES-1:0] dq_out,
  output logic [LANES-1:0] dq_oe,
  output logic             phase_done,
  output logic             cfg_err
);
  phase_cfg_t       ins_cfg, adr_cfg, ld_cfg;
  logic             start_acc, ld, adv, clr, ld_adr;
  logic [VAL_W-1:0] adr_q, ld_val;
  logic [BW-1:0]    ld_bits;

  cps_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .lock(busy || start_acc),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .ins_cfg(ins_cfg), .adr_cfg(adr_cfg)
  );

  cps_seq #(.VAL_W(VAL_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .ins_cfg(ins_cfg), .adr_cfg(adr_cfg),
    .busy(busy), .sclk(sclk), .phase_done(phase_done), .cfg_err(cfg_err),
    .start_acc(start_acc), .ld(ld), .adv(adv), .clr(clr), .ld_adr(ld_adr),
    .ld_cfg(ld_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) adr_q <= '0;
    else if (start_acc) adr_q <= addr_val;
  end

  always_comb begin
    if (!ld_adr)        ld_val = instr_val;
    else if (start_acc) ld_val = addr_val;
    else                ld_val = adr_q;
    ld_bits = BW'({({1'b0, ld_cfg.size} + 3'd1), 3'b000});
  end

  cps_lane_shifter #(.VAL_W(VAL_W), .LANES(LANES)) u_shift (
    .clk(clk), .rst(rst), .ld(ld), .adv(adv), .clr(clr),
    .ld_val(ld_val), .ld_bits(ld_bits), .ld_llog(lanes_log(ld_cfg.mode)),
    .dq(dq_out), .oe(dq_oe)
  );
endmodule

// File: rtl/cps_chk.sv
module cps_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             sclk,
  input logic [LANES-1:0] dq_out,
  input logic [LANES-1:0] dq_oe,
  input logic             phase_done,
  input logic             cfg_err,
  input logic [15:0]      cfg_rdata
);
  a_r10_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  a_r4_oe_low_lanes: assert property (@(posedge clk) disable iff (rst)
    ((dq_oe & (dq_oe + 1'b1)) == '0));

  a_r4_no_drive_off_lane: assert property (@(posedge clk) disable iff (rst)
    ((dq_out & ~dq_oe) == '0));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (dq_oe == '0 && dq_out == '0 && !sclk));

  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_rdata));

  a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !cfg_err);

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    phase_done |=> !phase_done);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata & 16'hC0C0) == 16'h0000);
endmodule

bind cmd_phase_ser cps_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .sclk(sclk),
  .dq_out(dq_out), .dq_oe(dq_oe), .phase_done(phase_done),
  .cfg_err(cfg_err), .cfg_rdata(cfg_rdata)
);

// File: tb/sim_cmd_phase_ser.sv
`timescale 1ns/1ps
module sim_cmd_phase_ser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_rdata;
  logic [31:0] instr_val = '0;
  logic [31:0] addr_val = '0;
  logic        start = 1'b0;
  logic        busy, sclk, phase_done, cfg_err;
  logic [7:0]  dq_out, dq_oe;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  cmd_phase_ser u0 (
    .clk(clk), .rst(rst), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
    .instr_val(instr_val), .addr_val(addr_val), .start(start), .busy(busy), .sclk(sclk),
    .dq_out(dq_out), .dq_oe(dq_oe), .phase_done(phase_done), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] w);
    @(negedge clk);
    cfg_wdata = w;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one command and checks every tick against a model built from the word.
  task automatic run_txn(input logic [15:0] w, input logic [31:0] iv, input logic [31:0] av, input string tag);
    logic [2:0] m;
    logic [31:0] v, e;
    int nbits, nl, beats, nt, b;
    bit dtr, any, first, pend, errx;
    do_write(w);
    errx = (w[2:0] > 3'd4) || (w[10:8] > 3'd4);
    any = 1'b0; first = 1'b1; pend = 1'b0;
    instr_val = iv; addr_val = av; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int p = 0; p < 2; p++) begin
      m     = p ? w[10:8] : w[2:0];
      dtr   = p ? w[11] : w[3];
      nbits = 8 * ((p ? int'(w[13:12]) : int'(w[5:4])) + 1);
      v     = p ? av : iv;
      if (m >= 3'd1 && m <= 3'd4) begin
        any   = 1'b1;
        nl    = 1 << (m - 1);
        beats = nbits / nl;
        nt    = dtr ? beats + (beats % 2) : 2 * beats;
        for (int t = 0; t < nt; t++) begin
          b = dtr ? t : t / 2;
          e = (b < beats) ? ((v >> (nbits - (b + 1) * nl)) & ((32'd1 << nl) - 1)) : 32'd0;
          chk("R10", "busy", busy, 1);
          chk("R5", "sclk", sclk, t % 2);
          chk("R4", "oe", dq_oe, (32'd1 << nl) - 1);
          chk(tag, "dq", dq_out, e);
          chk("R11", "done", phase_done, pend);
          chk("R9", "err", cfg_err, first ? errx : 1'b0);
          pend = 1'b0; first = 1'b0;
          @(negedge clk);
        end
        pend = 1'b1;
      end
    end
    if (!any) begin
      chk("R10", "busy one cycle", busy, 1);
      chk("R8", "oe skipped", dq_oe, 0);
      chk("R9", "err", cfg_err, errx);
      @(negedge clk);
    end
    chk("R10", "busy end", busy, 0);
    chk("R12", "idle oe", dq_oe, 0);
    chk("R12", "idle dq", dq_out, 0);
    chk("R12", "idle sclk", sclk, 0);
    chk("R11", "done end", phase_done, pend);
    @(negedge clk);
    chk("R11", "done low", phase_done, 0);
    chk("R9", "err low", cfg_err, 0);
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "sclk", sclk, 0);
    chk("R1", "dq", dq_out, 0);
    chk("R1", "oe", dq_oe, 0);
    chk("R1", "done", phase_done, 0);
    chk("R1", "err", cfg_err, 0);
    chk("R1", "cfg", cfg_rdata, 0);
  endtask

  task automatic t_cfg_rw();
    do_write(16'hFFFF);
    chk("R2", "reserved bits", cfg_rdata, 16'h3F3F);
    do_write(16'h2A0C);
    chk("R2", "readback", cfg_rdata, 16'h2A0C);
  endtask

  task automatic t_lock();
    int n;
    do_write(16'h0001);
    @(negedge clk);
    instr_val = 32'h5A; start = 1'b1; cfg_wdata = 16'h3F3F; cfg_we = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      if (n == 4) start = 1'b1;
      if (n == 5) start = 1'b0;
      n++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    start = 1'b0;
    chk("R10", "busy length with start while busy", n, 16);
    chk("R3", "cfg locked", cfg_rdata, 16'h0001);
    @(negedge clk);
    chk("R10", "ignored start stays idle", busy, 0);
  endtask

  initial begin
    #(4ns * 200000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cfg_rw();
    t_lock();
    run_txn(16'h2101, 32'hA5, 32'h00C3_5E17, "R7");
    run_txn(16'h3B13, 32'hBEEF, 32'h1234_5678, "R5");
    run_txn(16'h3C1C, 32'h9C3A, 32'hDEAD_BEEF, "R6");
    run_txn(16'h2A0C, 32'h7E, 32'h00A1_B2C3, "R6");
    run_txn(16'h0100, 32'hFF, 32'h96, "R8");
    run_txn(16'h0000, 32'h1, 32'h2, "R8");
    run_txn(16'h1105, 32'hFF, 32'h00004321, "R9");
    run_txn(16'h0706, 32'h1, 32'h2, "R9");
    run_txn(16'h3322, 32'h00AB_CDEF, 32'hF0F0_1234, "R4");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule